// File: doc/BRIEF.md
# CSR Row Decoder with Empty-Row Skipping

This block sits at the head of a sparse matrix-vector pipeline. It takes a merged stream of 32-bit compressed-sparse-row words, one word per clock at most. Each ordinary word carries the nonzero count of the next row. The block turns it into a row descriptor (row index and count) for the multiply datapath. A word with its top bit set stands for a whole run of empty rows. The row counter jumps past that run in the same cycle, so a long gap between populated rows costs one clock instead of one clock per row.

The block also owns the on-chip accumulation buffer. That buffer keeps one partial sum per row while the matrix is processed column block by column block. The datapath returns each row's block result tagged with the row index, and the block adds it to the sum stored for that row. A sideband flag on the last word of a block restarts the row counter at zero and records how many rows the block spanned. A drain request then streams the finished sums out in row order, marking the final one. At the end of the drain every entry is marked empty, so the next matrix starts from zero without a clearing pass.

Top module: `csr_row_walker`

## Requirements
- R1: `in_ready` is high in every cycle in which no drain is in progress, and a word offered while `in_ready` is high is consumed at that clock edge; at most one word is consumed per clock.
- R2: A consumed word with bit 31 low yields, one cycle later, `rd_valid`=1, `rd_row` equal to the current row counter and `rd_nnz` equal to bits 30:0; the row counter then advances by one.
- R3: A consumed word with bit 31 high and a nonzero length L in bits 30:0 yields no descriptor and advances the row counter by L at that single edge, so the next ordinary row carries an index L higher.
- R4: A run word with length zero yields no descriptor and leaves the row counter unchanged.
- R5: When `in_eob` accompanies a consumed word, the word is applied first, the resulting counter value becomes the block's row count, and the counter returns to zero, so the next ordinary row is row 0.
- R6: A cycle with `psum_valid` high adds `psum_data` to the entry at `psum_addr`, modulo 2^DW; the first value written to an entry since the last clear replaces its contents.
- R7: An entry that received no partial sum since the last clear reads as zero when drained.
- R8: A `drain_start` accepted while idle with a nonzero row count produces, from the next cycle, one output per cycle for rows 0 up to count-1 in order, with `out_last` on the final row only; `in_ready` stays low until that final output is shown.
- R9: After a drain completes, every entry counts as empty, so sums from the next pass do not include earlier contents.
- R10: `drain_start` has no effect while a drain is in progress or while the recorded row count is zero.
- R11: After reset `in_ready` is 1, `rd_valid` is 0, `out_valid` is 0 and the row counter and row count are 0.
- R12: The row counter may reach but never exceed DEPTH; a block may span exactly DEPTH rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream word offered |
| in_ready | output | 1 | Block can consume a word this cycle |
| in_word | input | 32 | Bit 31 set: empty-row run, length in 30:0; clear: row nonzero count in 30:0 |
| in_eob | input | 1 | Word is the last of its column block |
| rd_valid | output | 1 | Row descriptor present |
| rd_row | output | AW | Row index of the descriptor |
| rd_nnz | output | 31 | Nonzero count of the row |
| psum_valid | input | 1 | Block partial sum offered |
| psum_addr | input | AW | Row the partial sum belongs to |
| psum_data | input | DW | Partial sum value |
| drain_start | input | 1 | Request to stream out the accumulated sums |
| out_valid | output | 1 | Drained sum present |
| out_row | output | AW | Row of the drained sum |
| out_data | output | DW | Accumulated sum |
| out_last | output | 1 | Final row of the drain |

## Verification
The bench builds the block with DEPTH=8 and DW=32. That shallow buffer lets one short block reach the full-depth boundary: a closing empty run lands the counter exactly on DEPTH. The same drain then covers every entry, including rows that never received a sum. With only eight rows, a second pass fits in a few cycles, so residue left after clearing would show up at once. The bench also holds a word waiting during a drain and repeats a drain request within a drain.

// File: rtl/csrw_pkg.sv
package csrw_pkg;
   localparam int WORD_W = 32;
   localparam int LEN_W  = WORD_W - 1;

   typedef struct packed {
      logic             is_run;
      logic [LEN_W-1:0] len;
   } csr_word_t;
endpackage

// File: rtl/csrw_decode.sv
module csrw_decode
   import csrw_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = 4,
   parameter int ROW_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_fire,
   input  csr_word_t        in_word,
   input  logic             in_eob,
   output logic             rd_valid,
   output logic [AW-1:0]    rd_row,
   output logic [LEN_W-1:0] rd_nnz,
   output logic [ROW_W-1:0] nrows
);
   logic [ROW_W-1:0] row_cnt;
   logic [LEN_W:0]   step;
   logic [LEN_W:0]   nxt;

   // one adder serves both a single row and a whole run
   always_comb begin
      step = in_word.is_run ? {1'b0, in_word.len} : (LEN_W+1)'(1);
      nxt  = (LEN_W+1)'(row_cnt) + step;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_row   <= '0;
         rd_nnz   <= '0;
         row_cnt  <= '0;
         nrows    <= '0;
      end else begin
         rd_valid <= in_fire && !in_word.is_run;
         if (in_fire) begin
            if (!in_word.is_run) begin
               rd_row <= row_cnt[AW-1:0];
               rd_nnz <= in_word.len;
            end
            if (in_eob) begin
               nrows   <= nxt[ROW_W-1:0];
               row_cnt <= '0;
            end else begin
               row_cnt <= nxt[ROW_W-1:0];
            end
         end
      end
   end

   AST_DESC_FROM_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(in_fire && !in_word.is_run));                       // R2
   AST_RUN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fire && in_word.is_run) |=> !rd_valid);                             // R3
   AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      in_fire |-> (nxt <= (LEN_W+1)'(DEPTH)));                                // R12
endmodule

// File: rtl/csrw_accum.sv
module csrw_accum #(
   parameter int DEPTH = 16,
   parameter int DW    = 32,
   parameter int AW    = 4,
   parameter int ROW_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             psum_valid,
   input  logic [AW-1:0]    psum_addr,
   input  logic [DW-1:0]    psum_data,
   input  logic             drain_start,
   input  logic [ROW_W-1:0] nrows,
   output logic             draining,
   output logic             out_valid,
   output logic [AW-1:0]    out_row,
   output logic [DW-1:0]    out_data,
   output logic             out_last
);
   logic [DW-1:0]    mem [DEPTH];
   logic [DEPTH-1:0] filled;
   logic [AW-1:0]    dptr;
   logic             at_end;
   logic             clr;
   logic [DW-1:0]    acc_old;
   logic [DW-1:0]    acc_new;

   assign at_end  = (ROW_W'(dptr) + ROW_W'(1)) == nrows;
   assign clr     = draining && at_end;
   assign acc_old = filled[psum_addr] ? mem[psum_addr] : '0;
   assign acc_new = acc_old + psum_data;

   always_ff @(posedge clk) begin
      if (psum_valid) mem[psum_addr] <= acc_new;
   end

   // per-entry flags: a clear costs one cycle, not DEPTH writes
   always_ff @(posedge clk) begin
      if (!rst_n)          filled <= '0;
      else if (clr)        filled <= '0;
      else if (psum_valid) filled[psum_addr] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         draining  <= 1'b0;
         dptr      <= '0;
         out_valid <= 1'b0;
         out_row   <= '0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else begin
         out_valid <= draining;
         out_last  <= clr;
         if (draining) begin
            out_row  <= dptr;
            out_data <= filled[dptr] ? mem[dptr] : '0;
            if (at_end) draining <= 1'b0;
            else        dptr     <= dptr + AW'(1);
         end else if (drain_start && nrows != '0) begin
            draining <= 1'b1;
            dptr     <= '0;
         end
      end
   end

   AST_DRAIN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |=> !out_valid);                                // R8
   AST_DRAIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> (out_valid && out_row == $past(out_row) + AW'(1))); // R8
   AST_FRESH_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> (filled == '0));                            // R9
endmodule

// File: rtl/csr_row_walker.sv
module csr_row_walker
   import csrw_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int DW    = 32,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int ROW_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   input  logic              in_eob,
   output logic              rd_valid,
   output logic [AW-1:0]     rd_row,
   output logic [LEN_W-1:0]  rd_nnz,
   input  logic              psum_valid,
   input  logic [AW-1:0]     psum_addr,
   input  logic [DW-1:0]     psum_data,
   input  logic              drain_start,
   output logic              out_valid,
   output logic [AW-1:0]     out_row,
   output logic [DW-1:0]     out_data,
   output logic              out_last
);
   initial begin
      assert (DEPTH >= 2) else $error("csr_row_walker: DEPTH must be at least 2");
      assert (DW >= 1)    else $error("csr_row_walker: DW must be positive");
   end

   logic             draining;
   logic             in_fire;
   logic [ROW_W-1:0] nrows;
   csr_word_t        word;

   assign in_ready = !draining;
   assign in_fire  = in_valid && in_ready;
   assign word     = csr_word_t'(in_word);

   csrw_decode #(.DEPTH(DEPTH), .AW(AW), .ROW_W(ROW_W)) u_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_fire  (in_fire),
      .in_word  (word),
      .in_eob   (in_eob),
      .rd_valid (rd_valid),
      .rd_row   (rd_row),
      .rd_nnz   (rd_nnz),
      .nrows    (nrows)
   );

   csrw_accum #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .ROW_W(ROW_W)) u_accum (
      .clk         (clk),
      .rst_n       (rst_n),
      .psum_valid  (psum_valid),
      .psum_addr   (psum_addr),
      .psum_data   (psum_data),
      .drain_start (drain_start),
      .nrows       (nrows),
      .draining    (draining),
      .out_valid   (out_valid),
      .out_row     (out_row),
      .out_data    (out_data),
      .out_last    (out_last)
   );

   AST_HOLD_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> !in_ready);                                // R8
   AST_NO_DESC_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready) |=> !rd_valid);                                             // R1
endmodule

// File: tb/csr_row_walker_tb.sv
module csr_row_walker_tb;
   localparam int DEPTH = 8;
   localparam int DW    = 32;
   localparam int AW    = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [31:0]   in_word = '0;
   logic          in_eob = 1'b0;
   logic          rd_valid;
   logic [AW-1:0] rd_row;
   logic [30:0]   rd_nnz;
   logic          psum_valid = 1'b0;
   logic [AW-1:0] psum_addr = '0;
   logic [DW-1:0] psum_data = '0;
   logic          drain_start = 1'b0;
   logic          out_valid;
   logic [AW-1:0] out_row;
   logic [DW-1:0] out_data;
   logic          out_last;

   always #10 clk = ~clk;

   csr_row_walker #(.DEPTH(DEPTH), .DW(DW)) u_dut (.*);

   int total = 0;
   int bad   = 0;

   // behavioural reference
   int          m_cnt, m_nrows, m_dptr;
   bit          m_drain;
   logic [31:0] m_buf [DEPTH];
   bit          m_fill [DEPTH];
   bit          e_rd_valid, e_out_valid, e_out_last;
   int          e_rd_row, e_rd_nnz, e_out_row;
   logic [31:0] e_out_data;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_nrows = 0; m_dptr = 0; m_drain = 0;
         e_rd_valid = 0; e_out_valid = 0; e_out_last = 0;
         for (int i = 0; i < DEPTH; i++) m_fill[i] = 0;
      end else begin
         bit fire, clear;
         fire = in_valid && !m_drain;
         clear = 0;
         e_rd_valid = 0; e_out_valid = 0; e_out_last = 0;
         if (fire) begin
            if (in_word[31]) m_cnt = m_cnt + int'(in_word[30:0]);
            else begin
               e_rd_valid = 1; e_rd_row = m_cnt; e_rd_nnz = int'(in_word[30:0]);
               m_cnt = m_cnt + 1;
            end
            if (in_eob) begin m_nrows = m_cnt; m_cnt = 0; end
         end
         if (m_drain) begin
            e_out_valid = 1; e_out_row = m_dptr;
            e_out_data = m_fill[m_dptr] ? m_buf[m_dptr] : 32'd0;
            e_out_last = (m_dptr == m_nrows - 1);
            if (e_out_last) begin m_drain = 0; clear = 1; end
            else m_dptr = m_dptr + 1;
         end else if (drain_start && m_nrows != 0) begin
            m_drain = 1; m_dptr = 0;
         end
         if (psum_valid) begin
            m_buf[psum_addr] = m_fill[psum_addr] ? m_buf[psum_addr] + psum_data : psum_data;
            m_fill[psum_addr] = 1;
         end
         if (clear) for (int i = 0; i < DEPTH; i++) m_fill[i] = 0;
      end
   end

   logic [31:0] got [DEPTH];
   int          n_out = 0;
   bit          seen_last = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic compare();
      chk(in_ready == !m_drain, "R1 in_ready", in_ready, !m_drain);
      chk(rd_valid == e_rd_valid, "R2 rd_valid", rd_valid, e_rd_valid);
      if (e_rd_valid && rd_valid) begin
         chk(rd_row == AW'(e_rd_row), "R2 rd_row", rd_row, e_rd_row);
         chk(rd_nnz == 31'(e_rd_nnz), "R2 rd_nnz", rd_nnz, e_rd_nnz);
      end
      chk(out_valid == e_out_valid, "R8 out_valid", out_valid, e_out_valid);
      if (e_out_valid && out_valid) begin
         chk(out_row == AW'(e_out_row), "R8 out_row", out_row, e_out_row);
         chk(out_data == e_out_data, "R6 out_data", out_data, e_out_data);
         chk(out_last == e_out_last, "R8 out_last", out_last, e_out_last);
      end
      if (out_valid) begin
         got[out_row] = out_data;
         n_out++;
         if (out_last) seen_last = 1;
      end
   endtask

   task automatic step();
      @(negedge clk);
      compare();
   endtask

   task automatic send(input bit run, input int val, input bit eob);
      bit ok;
      in_valid = 1; in_word = {run, 31'(val)}; in_eob = eob;
      do begin
         ok = in_ready;
         step();
      end while (!ok);
      in_valid = 0; in_word = '0; in_eob = 0;
   endtask

   task automatic psum(input int a, input int d);
      psum_valid = 1; psum_addr = AW'(a); psum_data = 32'(d);
      step();
      psum_valid = 0;
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (4000) @(posedge clk);
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      step();
      // R11 reset state
      chk(in_ready == 1, "R11 in_ready", in_ready, 1);
      chk(rd_valid == 0, "R11 rd_valid", rd_valid, 0);
      chk(out_valid == 0, "R11 out_valid", out_valid, 0);

      // R10 drain request with no recorded rows
      drain_start = 1; step(); drain_start = 0;
      step(); step();
      chk(n_out == 0, "R10 no drain at zero rows", n_out, 0);

      // block 0
      send(0, 5, 0);
      chk(rd_row == 0 && rd_nnz == 5, "R2 first row", rd_nnz, 5);
      psum(0, 100);
      send(1, 2, 0);
      send(0, 3, 0);
      chk(rd_row == 3, "R3 row after run of 2", rd_row, 3);
      psum(3, 30);
      send(1, 0, 0);
      send(0, 1, 0);
      chk(rd_row == 4, "R4 zero run is no-op", rd_row, 4);
      psum(4, 7);
      send(1, 3, 1);            // counter lands on DEPTH, R12

      // block 1
      send(0, 2, 0);
      chk(rd_row == 0, "R5 counter restarts after block end", rd_row, 0);
      psum(0, 11);
      send(1, 4, 0);
      send(0, 9, 0);
      chk(rd_row == 5, "R3 row after run of 4", rd_row, 5);
      psum(5, 50);
      send(1, 2, 1);

      // drain pass 1; a word waits through it
      n_out = 0; seen_last = 0;
      drain_start = 1; step(); drain_start = 0;
      send(0, 1, 1);
      chk(seen_last == 1, "R8 drain finished", seen_last, 1);
      chk(n_out == DEPTH, "R12 full-depth drain", n_out, DEPTH);
      chk(got[0] == 111, "R6 sum across blocks", got[0], 111);
      chk(got[1] == 0, "R7 untouched row", got[1], 0);
      chk(got[7] == 0, "R7 last untouched row", got[7], 0);
      chk(got[5] == 50, "R6 single contribution", got[5], 50);
      chk(rd_row == 0 && rd_valid == 1, "R1 held word accepted after drain", rd_row, 0);

      // pass 2: fresh buffer, repeated drain request
      psum(0, 5);
      n_out = 0; seen_last = 0;
      drain_start = 1; step(); step(); drain_start = 0;
      step(); step();
      chk(n_out == 1, "R10 request during drain ignored", n_out, 1);
      chk(got[0] == 5, "R9 no residue from earlier pass", got[0], 5);
      chk(seen_last == 1, "R8 single-row drain marks last", seen_last, 1);

      summary();
      $finish;
   end
endmodule